// File: doc/BRIEF.md
# SDRAM Column Data Path

This block is the data engine that sits behind the command decoder of a synchronous DRAM device model. The decoder hands it one column access per clock. Each access is a read command, a write command, or a continuation beat of the burst already running, and each carries its column address. The decoder also supplies a precharge strobe, the per-cycle byte mask and the programmed read latency. The block keeps a small register array. Write words are stored on the same edge that samples the write. Read words come out of a pipeline whose tap is set by the latency, together with the enable for the shared 8-bit bus.

Both data directions behave as valid-only streams with no back-pressure. On the write side, `wr_stb` is the valid for `wr_data`, and it rises in the same cycle as the accepted, unmasked write beat. On the read side, `dq_oe` is the valid for `dq_out`. Whoever receives either stream must take every word in the cycle it is offered, because nothing can stall the path. The bus has no ready signal, and the latency of a word cannot change once it is in flight.

Precharge ends a burst. Read words already in the pipe still drain for one cycle fewer than the latency, and then the bus floats. A new column command may replace the running burst on any cycle. Read words already in flight still reach the bus in their own slots. A write drops every queued read word so that the two directions never overlap.

Top module: `sdram_dpath`

## Requirements
- R1: After reset, `dq_oe` and `wr_stb` are low, `dq_out` is 0, and no read word is queued.
- R2: With `cas_lat3`=0 (latency 2), a read accepted in cycle c places the array word at its column on `dq_out` with `dq_oe` high during cycle c+2.
- R3: With `cas_lat3`=1 (latency 3), a read accepted in cycle c is on the bus during cycle c+3.
- R4: `dqm` high in cycle c forces `dq_oe` low and `dq_out` to 0 during cycle c+2, at either latency, and hides that read word.
- R5: An accepted write beat raises `wr_stb` in the same cycle, with `wr_data` equal to `dq_in`. The word is stored at its column on that clock edge, so a later read returns it.
- R6: `dqm` high in a write-beat cycle keeps `wr_stb` low in that same cycle and leaves the addressed array word unchanged.
- R7: `pre_cmd` in cycle c ends the burst. A read or beat in cycle c, and beats after it, are not accepted. The bus is at high impedance from cycle c+2 (latency 2) or c+3 (latency 3) onward. Words already queued still appear before that.
- R8: A new `rd_cmd` may be given on any cycle, even every cycle. It starts a burst at its column, and words already queued still leave in their own slots.
- R9: An accepted write in cycle c drops every queued read word, and `dq_oe` is low from cycle c onward until a later read reaches the bus.
- R10: `dq_oe` is high only in a cycle carrying a valid, unmasked read word, and `dq_out` is 0 whenever `dq_oe` is low.
- R11: `beat` is ignored when no burst is open: after reset, after precharge, and in a direction other than that of the open burst.
- R12: When several commands share a cycle, the priority is precharge, then read, then write, then beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | Read latency select: 0 = 2 clocks, 1 = 3 clocks; change only while idle |
| rd_cmd | input | 1 | Read column command, starts a read burst |
| wr_cmd | input | 1 | Write column command, starts a write burst |
| beat | input | 1 | Continuation beat of the open burst |
| pre_cmd | input | 1 | Precharge, closes the open burst |
| col | input | COL_W | Column address of this cycle's access |
| dqm | input | 1 | Byte mask for this cycle |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus, 0 when not driven |
| dq_oe | output | 1 | Bus drive enable, the valid for `dq_out` |
| wr_stb | output | 1 | Write word valid, the store strobe |
| wr_data | output | DATA_W | Write word being stored |

## Verification
The hardest case to reach is a precharge or a write that lands while read words are still queued in the pipeline. It becomes harder when a mask aimed at one of those same slots is added, because the outcome then depends on which words were in flight and on the latency selected. The stimulus reaches this case with bursts that carry a mask or a precharge at a chosen beat, run at both latencies. It follows them with a long stretch of random commands and masks that an independent cycle-indexed model schedules. Every cycle, the scoreboard compares the expected bus enable, the read word, the write strobe and the write word.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // Direction of the burst currently open.
  typedef enum logic [1:0] {
    BURST_IDLE = 2'd0,
    BURST_RD   = 2'd1,
    BURST_WR   = 2'd2
  } burst_e;
endpackage

// File: rtl/sdp_array.sv
module sdp_array #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  // R5: a strobed word is in the array after the edge.
  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sdp_delay.sv
module sdp_delay #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe #(
  parameter int DATA_W = 8,
  parameter int MAX_CL = 3,
  localparam int IDX_W = $clog2(MAX_CL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [IDX_W-1:0]  lat_sel,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic [MAX_CL-1:0]             vld_q;
  logic [MAX_CL-1:0][DATA_W-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q[0] <= in_vld & ~flush;
      dat_q[0] <= in_data;
      for (int s = 1; s < MAX_CL; s++) begin
        vld_q[s] <= vld_q[s-1] & ~flush;
        dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign out_vld  = vld_q[lat_sel];
  assign out_data = dat_q[lat_sel];

  // R9: a flush leaves nothing queued on the next cycle.
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld_q == '0);
endmodule

// File: rtl/sdram_dpath.sv
module sdram_dpath #(
  parameter int DATA_W   = 8,
  parameter int COL_W    = 4,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat3,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              beat,
  input  logic              pre_cmd,
  input  logic [COL_W-1:0]  col,
  input  logic              dqm,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data
);
  import sdp_pkg::*;

  localparam int IDX_W = $clog2(MAX_CL);

  burst_e            mode_q, mode_d;
  logic              rd_acc, wr_now;
  logic [DATA_W-1:0] arr_rdata;
  logic [IDX_W-1:0]  tap;
  logic              sel_vld;
  logic [DATA_W-1:0] sel_data;
  logic              mask_late;

  // Acceptance: precharge > read > write > continuation beat.
  always_comb begin
    rd_acc = !pre_cmd && (rd_cmd || (beat && !wr_cmd && mode_q == BURST_RD));
    wr_now = !pre_cmd && !rd_cmd && (wr_cmd || (beat && mode_q == BURST_WR));
    mode_d = mode_q;
    if (pre_cmd)     mode_d = BURST_IDLE;
    else if (rd_cmd) mode_d = BURST_RD;
    else if (wr_cmd) mode_d = BURST_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= BURST_IDLE;
    else        mode_q <= mode_d;
  end

  // Write side: mask acts in the command cycle itself.
  assign wr_stb  = wr_now && !dqm;
  assign wr_data = dq_in;

  sdp_array #(.DATA_W(DATA_W), .COL_W(COL_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_stb),
    .waddr (col),
    .wdata (dq_in),
    .raddr (col),
    .rdata (arr_rdata)
  );

  // Read side: latency picks the pipeline tap.
  assign tap = cas_lat3 ? IDX_W'(2) : IDX_W'(1);

  sdp_rd_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (wr_now),
    .in_vld   (rd_acc),
    .in_data  (arr_rdata),
    .lat_sel  (tap),
    .out_vld  (sel_vld),
    .out_data (sel_data)
  );

  sdp_delay #(.WIDTH(1), .STAGES(MASK_LAT)) u_mask_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (dqm),
    .dout  (mask_late)
  );

  assign dq_oe  = sel_vld && !mask_late && !wr_now;
  assign dq_out = dq_oe ? sel_data : '0;

  // R2: latency-2 read reaches the tap two cycles on.
  p_cl2_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !cas_lat3) ##1 (!wr_now && !cas_lat3) |=> sel_vld);

  // R3: latency-3 read reaches the tap three cycles on.
  p_cl3_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && cas_lat3) ##1 (!wr_now && cas_lat3) ##1 (!wr_now && cas_lat3)
    |=> sel_vld);

  // R4: mask floats the bus two cycles later.
  p_rd_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> ##2 !dq_oe);

  // R7: precharge floats the bus after the latency.
  p_pre_cl2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cmd && !cas_lat3) ##1 !cas_lat3 |=> !dq_oe);
  p_pre_cl3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cmd && cas_lat3) ##1 cas_lat3 ##1 cas_lat3 |=> !dq_oe);

  // R9: a write leaves no read word at the tap next cycle.
  p_no_contend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> !sel_vld);
endmodule

// File: tb/tb_sdram_dpath.sv
module tb_sdram_dpath;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cas_lat3;
  logic       rd_cmd, wr_cmd, beat, pre_cmd, dqm;
  logic [3:0] col;
  logic [7:0] dq_in;
  logic [7:0] dq_out;
  logic       dq_oe;
  logic       wr_stb;
  logic [7:0] wr_data;

  always #2 clk = ~clk;

  sdram_dpath dut (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .beat(beat), .pre_cmd(pre_cmd),
    .col(col), .dqm(dqm), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_stb(wr_stb), .wr_data(wr_data)
  );

  typedef struct {
    int         t;
    bit         oe;
    logic [7:0] dq;
    bit         stb;
    logic [7:0] wd;
    string      req;
  } item_t;

  item_t      sb_q[$];
  int         errors = 0;
  int         checks = 0;
  int         cyc_n  = 0;
  int         lat    = 2;
  int         mode   = 0;   // 0 idle, 1 read, 2 write
  string      cur_req = "R1";
  logic [7:0] ref_mem [16];
  bit         sched_v [4096];
  logic [7:0] sched_d [4096];
  bit         blk     [4096];
  bit         done    = 0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: one cycle of stimulus plus the model's expectation for it.
  task automatic cyc(bit rd, bit wr, bit bt, bit pr, bit m, logic [3:0] c, logic [7:0] d);
    bit ra, wn, stb;
    item_t it;
    @(negedge clk);
    rd_cmd = rd; wr_cmd = wr; beat = bt; pre_cmd = pr; dqm = m; col = c; dq_in = d;
    cas_lat3 = (lat == 3);
    ra  = !pr && (rd || (bt && !wr && mode == 1));
    wn  = !pr && !rd && (wr || (bt && mode == 2));
    stb = wn && !m;
    if (pr) mode = 0; else if (rd) mode = 1; else if (wr) mode = 2;
    if (wn) for (int t = cyc_n + 1; t < cyc_n + 8; t++) sched_v[t] = 0;
    if (ra) begin
      sched_v[cyc_n + lat] = 1;
      sched_d[cyc_n + lat] = ref_mem[c];
    end
    if (m) blk[cyc_n + 2] = 1;
    it.t   = cyc_n;
    it.oe  = sched_v[cyc_n] && !blk[cyc_n] && !wn;
    it.dq  = it.oe ? sched_d[cyc_n] : 8'h00;
    it.stb = stb;
    it.wd  = d;
    if (blk[cyc_n] && sched_v[cyc_n]) it.req = "R4";
    else if (wn && m)                 it.req = "R6";
    else if (wn && sched_v[cyc_n])    it.req = "R9";
    else                              it.req = cur_req;
    sb_q.push_back(it);
    if (stb) ref_mem[c] = d;
    cyc_n++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 4'd0, 8'h00);
  endtask

  task automatic wr_burst(int c0, int len, int mask_at, int base);
    for (int i = 0; i < len; i++)
      cyc(0, i == 0, i != 0, 0, i == mask_at, 4'((c0 + i) % 16), 8'(base + i * 7));
  endtask

  task automatic rd_burst(int c0, int len, int mask_at, int pre_at);
    for (int i = 0; i < len; i++) begin
      if (i == pre_at) cyc(0, 0, 1, 1, 0, 4'((c0 + i) % 16), 8'h00);
      else cyc(i == 0, 0, i != 0, 0, i == mask_at, 4'((c0 + i) % 16), 8'h00);
    end
  endtask

  // Monitor: pops one expectation per cycle and compares.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        checks++;
        if (dq_oe !== it.oe || dq_out !== it.dq || wr_stb !== it.stb ||
            (it.stb && wr_data !== it.wd)) begin
          errors++;
          $display("FAIL %s cycle %0d: oe=%0b dq=%02h stb=%0b wd=%02h expected oe=%0b dq=%02h stb=%0b wd=%02h",
                   it.req, it.t, dq_oe, dq_out, wr_stb, wr_data, it.oe, it.dq, it.stb, it.wd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'h00;
    for (int i = 0; i < 4096; i++) begin sched_v[i] = 0; sched_d[i] = 0; blk[i] = 0; end
    rst_n = 0; cas_lat3 = 0; rd_cmd = 0; wr_cmd = 0; beat = 0; pre_cmd = 0;
    dqm = 0; col = 0; dq_in = 0;
    repeat (3) @(negedge clk);
    #1;
    checks++;   // R1 during reset
    if (dq_oe !== 1'b0 || wr_stb !== 1'b0 || dq_out !== 8'h00) begin
      errors++;
      $display("FAIL R1 in reset: oe=%0b stb=%0b dq=%02h expected 0 0 00", dq_oe, wr_stb, dq_out);
    end
    rst_n = 1;

    cur_req = "R1";  idle(3);
    cur_req = "R11"; cyc(0, 0, 1, 0, 0, 4'd2, 8'h55); cyc(0, 0, 1, 0, 0, 4'd3, 8'h66); idle(3);

    cur_req = "R5";  wr_burst(0, 16, 3, 8'h11);   // col 3 masked: R6
    idle(2);

    lat = 2; cur_req = "R2";  rd_burst(0, 8, -1, -1); idle(4);
    lat = 3; cur_req = "R3";  rd_burst(8, 8, -1, -1); idle(4);
    cur_req = "R6";  cyc(1, 0, 0, 0, 0, 4'd3, 8'h00); idle(4);

    lat = 3; cur_req = "R4";  rd_burst(0, 8, 2, -1); idle(4);
    lat = 2; rd_burst(4, 8, 5, -1); idle(4);

    lat = 3; cur_req = "R7";  rd_burst(0, 8, -1, 3); idle(4);
    lat = 2; rd_burst(5, 8, -1, 4); idle(4);
    cur_req = "R11"; cyc(0, 0, 1, 0, 0, 4'd1, 8'h00); idle(3);

    lat = 3; cur_req = "R8";
    cyc(1, 0, 0, 0, 0, 4'd0, 0); cyc(0, 0, 1, 0, 0, 4'd1, 0); cyc(0, 0, 1, 0, 0, 4'd2, 0);
    cyc(1, 0, 0, 0, 0, 4'd9, 0); cyc(0, 0, 1, 0, 0, 4'd10, 0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 4'(15 - i), 0);
    idle(4);

    lat = 3; cur_req = "R9";
    rd_burst(0, 3, -1, -1); wr_burst(4, 3, -1, 8'hA0); idle(4);
    lat = 2; rd_burst(6, 2, -1, -1); cyc(0, 1, 0, 0, 0, 4'd12, 8'hC3); idle(4);

    cur_req = "R12";
    cyc(1, 0, 0, 1, 0, 4'd4, 0); idle(4);                  // precharge wins over read
    cyc(1, 1, 0, 0, 0, 4'd5, 8'hEE); idle(4);               // read wins over write
    cyc(0, 1, 0, 0, 0, 4'd6, 8'h3C); cyc(0, 1, 1, 0, 0, 4'd7, 8'h4D);
    cyc(0, 0, 1, 1, 0, 4'd8, 8'h5E); idle(4);               // precharge drops the beat

    cur_req = "R10";
    for (int blkn = 0; blkn < 2; blkn++) begin
      lat = (blkn == 0) ? 2 : 3;
      for (int i = 0; i < 120; i++) begin
        int r;
        r = $urandom_range(0, 15);
        cyc(r < 3, r == 3 || r == 4, r > 6, r == 5, $urandom_range(0, 5) == 0,
            4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)));
      end
      cyc(0, 0, 0, 1, 0, 4'd0, 0);
      idle(5);
    end

    idle(2);
    @(negedge clk); #2;
    done = 1;
    finish_run();
  end
endmodule